// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block is the slave side of a byte-wide shared address/data bus. The same eight lines first carry a location number and then the data for that location. The host uses four strobes: a high-active address strobe, and low-active chip select, read and write. The block keeps a small byte array behind the port. It writes into that array and reads back from it on the host's command. The pads themselves are outside the block, so the shared lines come in as `busIn` and go out as `busOut` together with a drive enable `busOe`.

All four strobes and the bus lines arrive asynchronously. Each passes through a two-stage synchroniser into a faster system clock domain. Strobe edges are detected there, and every internal action is timed from a detected edge. An action therefore happens three system clock edges after the pin changes.

The address strobe is not qualified by chip select. A host can therefore move the stored location without selecting the device, and a later selected access uses that location.

Top module: `muxbus_slave`

## Requirements
- R1: While reset is held and after its release, `busOe` is 0 and every array location reads back as 0x00; the stored location is 0.
- R2: On the falling edge of `aleIn`, the value on `busIn` becomes the stored location. Later accesses use that location until the next falling edge of `aleIn`.
- R3: A falling edge of `aleIn` updates the stored location even when `csN` is high. A read or write strobe while `csN` is high does not drive the bus and does not change the array.
- R4: A byte is written into the array at the rising edge of `wrN`. The value written is the one on `busIn` at that edge, provided `csN` stayed low from the falling edge of `wrN` onward.
- R5: If `csN` goes high while `wrN` is still low, that write is cancelled.
- R6: When `rdN` falls while `csN` is low, `busOe` goes to 1. It rises three clock edges after the pin change, and `busOut` then holds the byte at the stored location.
- R7: Once `rdN` returns high or `csN` returns high, `busOe` returns to 0 three clock edges later.
- R8: Only the low 7 bits of the stored location select a byte among 128. Bit 7 is ignored, so locations 0x85 and 0x05 are the same byte.
- R9: A write strobe that overlaps a read strobe writes nothing. The read output is still driven.
- R10: `busOut` does not change while `busOe` stays 1, even if the stored location is changed during the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled by it |
| rstN | input | 1 | Asynchronous reset, active low |
| aleIn | input | 1 | Address strobe, active high; its falling edge captures the location |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| busIn | input | 8 | Value currently present on the shared lines |
| busOut | output | 8 | Read data to drive onto the shared lines |
| busOe | output | 1 | Drive enable for the shared lines |

## Verification
Reads follow writes at several distinct locations and values, including the first and last locations and a location with bit 7 set. These patterns tell a working location latch apart from a stuck or aliased one.

A strobe sequence with the address strobe but no chip select, followed by a read that issues no new address, shows that the location moved without selection. Write and read strobes with chip select high show that no transfer took place.

A write aborted by chip select, and a write that overlaps a read, are each followed by a read-back. These separate a cancelled or suppressed write from one that landed. A change of location in the middle of a read shows whether the driven byte is held or follows the new location.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  // Strobes from control to datapath, all single-cycle except driveEn
  typedef struct packed {
    logic latchAddr;   // capture location from the bus
    logic captureRead; // copy addressed byte into the read holding register
    logic writeEn;     // write synchronised bus value into the array
    logic driveEn;     // level: read output enabled
  } busStrobes_t;

  // positions in the synchronised strobe vector (all active high)
  localparam int STB_ALE = 0;
  localparam int STB_RD  = 1;
  localparam int STB_WR  = 2;
  localparam int STB_CS  = 3;
  localparam int STB_NUM = 4;

endpackage

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
#(
  parameter int DATA_WIDTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  aleIn,
  input  logic                  csN,
  input  logic                  rdN,
  input  logic                  wrN,
  input  logic [DATA_WIDTH-1:0] busIn,
  output logic [DATA_WIDTH-1:0] busSync,
  output busStrobes_t           strobes
);

  logic [SYNC_STAGES-1:0][STB_NUM-1:0]    stbPipe;
  logic [SYNC_STAGES-1:0][DATA_WIDTH-1:0] busPipe;
  logic [STB_NUM-1:0] stbRaw;
  logic [STB_NUM-1:0] stbNow;
  logic [2:0]         stbPrev;   // ale, rd, wr history
  logic               rdActive;
  logic               wrArmed;

  assign stbRaw[STB_ALE] = aleIn;
  assign stbRaw[STB_RD]  = ~rdN;
  assign stbRaw[STB_WR]  = ~wrN;
  assign stbRaw[STB_CS]  = ~csN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbPipe <= '0;
      busPipe <= '0;
    end else begin
      stbPipe[0] <= stbRaw;
      busPipe[0] <= busIn;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        stbPipe[s] <= stbPipe[s-1];
        busPipe[s] <= busPipe[s-1];
      end
    end
  end

  assign stbNow  = stbPipe[SYNC_STAGES-1];
  assign busSync = busPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbPrev <= '0;
    else       stbPrev <= {stbNow[STB_WR], stbNow[STB_RD], stbNow[STB_ALE]};
  end

  logic aleFall, rdFall, wrFall, wrRise, selNow, rdNow;
  assign aleFall = stbPrev[0] & ~stbNow[STB_ALE];
  assign rdFall  = ~stbPrev[1] & stbNow[STB_RD];
  assign wrFall  = ~stbPrev[2] & stbNow[STB_WR];
  assign wrRise  = stbPrev[2] & ~stbNow[STB_WR];
  assign selNow  = stbNow[STB_CS];
  assign rdNow   = stbNow[STB_RD];

  // read window: opens on qualified strobe start, closes on strobe end or deselect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       rdActive <= 1'b0;
    else if (rdActive)               rdActive <= rdNow & selNow;
    else if (rdFall && selNow)       rdActive <= 1'b1;
  end

  // write qualification: selected at start, stays selected, no read overlap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            wrArmed <= 1'b0;
    else if (wrFall)                      wrArmed <= selNow & ~rdNow;
    else if (wrArmed && (!selNow || rdNow)) wrArmed <= 1'b0;
    else if (wrRise)                      wrArmed <= 1'b0;
  end

  always_comb begin
    strobes.latchAddr   = aleFall;
    strobes.captureRead = ~rdActive & rdFall & selNow;
    strobes.writeEn     = wrArmed & wrRise & selNow & ~rdNow;
    strobes.driveEn     = rdActive;
  end

endmodule

// File: rtl/muxbus_dpath.sv
module muxbus_dpath
  import muxbus_pkg::*;
#(
  parameter int DATA_WIDTH = 8,
  parameter int DEPTH      = 128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DATA_WIDTH-1:0] busSync,
  input  busStrobes_t           strobes,
  output logic [DATA_WIDTH-1:0] busOut,
  output logic                  busOe
);

  localparam int ADDR_BITS = $clog2(DEPTH);

  logic [ADDR_BITS-1:0]  addrQ;
  logic [DATA_WIDTH-1:0] mem [DEPTH];
  logic [DATA_WIDTH-1:0] readHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  addrQ <= '0;
    else if (strobes.latchAddr) addrQ <= busSync[ADDR_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobes.writeEn) begin
      mem[addrQ] <= busSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    readHold <= '0;
    else if (strobes.captureRead) readHold <= mem[addrQ];
  end

  assign busOut = readHold;
  assign busOe  = strobes.driveEn;

endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
  import muxbus_pkg::*;
#(
  parameter int DATA_WIDTH  = 8,
  parameter int DEPTH       = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  aleIn,
  input  logic                  csN,
  input  logic                  rdN,
  input  logic                  wrN,
  input  logic [DATA_WIDTH-1:0] busIn,
  output logic [DATA_WIDTH-1:0] busOut,
  output logic                  busOe
);

  busStrobes_t           strobes;
  logic [DATA_WIDTH-1:0] busSync;

  muxbus_ctrl #(
    .DATA_WIDTH (DATA_WIDTH),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrlI (
    .clk    (clk),
    .rstN   (rstN),
    .aleIn  (aleIn),
    .csN    (csN),
    .rdN    (rdN),
    .wrN    (wrN),
    .busIn  (busIn),
    .busSync(busSync),
    .strobes(strobes)
  );

  muxbus_dpath #(
    .DATA_WIDTH(DATA_WIDTH),
    .DEPTH     (DEPTH)
  ) dpathI (
    .clk    (clk),
    .rstN   (rstN),
    .busSync(busSync),
    .strobes(strobes),
    .busOut (busOut),
    .busOe  (busOe)
  );

endmodule

// File: rtl/muxbus_slave_chk.sv
module muxbus_slave_chk #(
  parameter int DATA_WIDTH = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  csN,
  input logic                  rdN,
  input logic [DATA_WIDTH-1:0] busOut,
  input logic                  busOe
);

  // R1
  always @(posedge clk) begin
    if (!rstN) reset_oe_chk: assert (!busOe);
  end

  // R6
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> !$past(csN, 3));

  // R7
  oe_needs_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> !$past(rdN, 3));

  // R10
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && $past(busOe)) |-> $stable(busOut));

endmodule

bind muxbus_slave muxbus_slave_chk #(.DATA_WIDTH(DATA_WIDTH)) chkI (
  .clk   (clk),
  .rstN  (rstN),
  .csN   (csN),
  .rdN   (rdN),
  .busOut(busOut),
  .busOe (busOe)
);

// File: tb/muxbus_slave_test.sv
module muxbus_slave_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       aleIn = 1'b0;
  logic       csN = 1'b1;
  logic       rdN = 1'b1;
  logic       wrN = 1'b1;
  logic [7:0] busIn = 8'h00;
  logic [7:0] busOut;
  logic       busOe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [7:0] model [128];

  always #5 clk = ~clk;

  muxbus_slave uut (
    .clk   (clk),
    .rstN  (rstN),
    .aleIn (aleIn),
    .csN   (csN),
    .rdN   (rdN),
    .wrN   (wrN),
    .busIn (busIn),
    .busOut(busOut),
    .busOe (busOe)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic putAddr(logic [7:0] a, bit sel);
    busIn = a;
    csN = !sel;
    step(2);
    aleIn = 1'b1;
    step(4);
    aleIn = 1'b0;
    step(4);
    csN = 1'b1;
    step(2);
  endtask

  task automatic writeByte(logic [7:0] a, logic [7:0] d, bit abortSel);
    putAddr(a, 1'b1);
    csN = 1'b0;
    busIn = d;
    step(2);
    wrN = 1'b0;
    step(4);
    if (abortSel) csN = 1'b1;
    step(4);
    wrN = 1'b1;
    step(4);
    csN = 1'b1;
    step(2);
    if (!abortSel) model[a[6:0]] = d;
  endtask

  task automatic readAt(logic [7:0] a, bit doAle, string tag);
    if (doAle) putAddr(a, 1'b1);
    csN = 1'b0;
    step(2);
    expQ.push_back('{model[a[6:0]], tag});
    rdN = 1'b0;
    step(6);
    check(busOe === 1'b1, {tag, " R6 drive"}, busOe, 1);
    rdN = 1'b1;
    step(5);
    check(busOe === 1'b0, "R7 release", busOe, 0);
    csN = 1'b1;
    step(2);
  endtask

  // monitor: pop an expected byte at each start of drive
  initial begin
    forever begin
      @(posedge busOe);
      #1;
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected drive", busOut, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(busOut === it.val, it.tag, busOut, it.val);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    step(5);
    check(busOe === 1'b0, "R1 reset oe", busOe, 0);
    rstN = 1'b1;
    step(3);
    check(busOe === 1'b0, "R1 after reset oe", busOe, 0);

    // R1: cleared array, location 0 by default
    readAt(8'h00, 1'b0, "R1 default loc");
    readAt(8'h7f, 1'b1, "R1 cleared");

    // R2 / R4: distinct locations and values
    writeByte(8'h10, 8'hA5, 1'b0);
    writeByte(8'h11, 8'h3C, 1'b0);
    writeByte(8'h7f, 8'hFF, 1'b0);
    readAt(8'h10, 1'b1, "R4 write");
    readAt(8'h11, 1'b1, "R2 loc");
    readAt(8'h7f, 1'b1, "R4 last loc");
    readAt(8'h10, 1'b1, "R2 reloc");

    // R8: bit 7 ignored
    writeByte(8'h85, 8'h33, 1'b0);
    readAt(8'h05, 1'b1, "R8 alias");

    // R5: write cancelled by deselect
    writeByte(8'h20, 8'h77, 1'b1);
    readAt(8'h20, 1'b1, "R5 abort");

    // R3: unselected address strobe still moves the location
    putAddr(8'h11, 1'b0);
    readAt(8'h11, 1'b0, "R3 unselected latch");

    // R3: unselected write and read do nothing
    putAddr(8'h10, 1'b0);
    busIn = 8'h99;
    step(2);
    wrN = 1'b0;
    step(4);
    wrN = 1'b1;
    step(4);
    rdN = 1'b0;
    step(6);
    check(busOe === 1'b0, "R3 unselected read", busOe, 0);
    rdN = 1'b1;
    step(4);
    readAt(8'h10, 1'b1, "R3 no write");

    // R9 / R10: write and location change during a read
    writeByte(8'h30, 8'h5E, 1'b0);
    writeByte(8'h31, 8'h61, 1'b0);
    putAddr(8'h30, 1'b1);
    csN = 1'b0;
    step(2);
    expQ.push_back('{8'h5E, "R10 read start"});
    rdN = 1'b0;
    step(6);
    busIn = 8'hC3;
    wrN = 1'b0;
    step(4);
    wrN = 1'b1;
    step(4);
    check(busOut === 8'h5E && busOe === 1'b1, "R9 read still driven", busOut, 8'h5E);
    busIn = 8'h31;
    aleIn = 1'b1;
    step(4);
    aleIn = 1'b0;
    step(4);
    check(busOut === 8'h5E, "R10 held data", busOut, 8'h5E);
    rdN = 1'b1;
    step(5);
    csN = 1'b1;
    step(2);
    readAt(8'h30, 1'b1, "R9 write suppressed");

    step(10);
    check(expQ.size() == 0, "R6 all reads driven", expQ.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule